// File: doc/BRIEF.md
# Presettable Binary/Decade Up-Down Counter

This block is a four-bit synchronous counter. It counts up or down, either in straight binary (0 to 15) or in BCD decade steps (0 to 9). The counting base and the direction are chosen at run time by two level inputs. A preset-enable input loads the counter from four jam inputs asynchronously, without waiting for a clock edge. While preset is high, those jam values appear on the count outputs directly.

An active-low carry-in acts as a clock enable. An active-low carry-out marks the terminal count for the current base and direction, and it only asserts while carry-in is low. Several stages can share one clock, with each stage's carry-out wired to the next stage's carry-in. The chain then counts as one multi-digit counter, with every digit changing on the same edge.

Top module: `jam_updown_counter`

## Requirements
- R1: While `rst_n` is low the count output is 0 immediately, without a clock edge (with `preset_en` low). Reset release takes effect through a two-stage synchronizer, so counting resumes no earlier than the second rising edge after `rst_n` rises.
- R2: While `preset_en` is high, `count` equals `jam` without waiting for a clock edge, so all-zero jam inputs show a zero count. After `preset_en` falls, the counter holds the jam value it sampled at the last rising edge with `preset_en` high.
- R3: On a rising edge where `carry_in_n` or `preset_en` is high, the count does not advance.
- R4: With `bin_sel`=1 (binary) and `up_sel`=1 (up), each enabled edge adds one, and 15 wraps to 0.
- R5: With `bin_sel`=1 and `up_sel`=0 (down), each enabled edge subtracts one, and 0 wraps to 15.
- R6: With `bin_sel`=0 (decade) and `up_sel`=1, each enabled edge adds one, and 9 wraps to 0. A preset value of 10 to 15 goes to 0 on the next enabled edge.
- R7: With `bin_sel`=0 and `up_sel`=0, each enabled edge subtracts one, and 0 wraps to 9. A value above 9 decrements normally.
- R8: `carry_out_n` is low exactly when `carry_in_n` is low and the visible count equals the terminal value. The terminal value is 15 (binary up), 9 (decade up) or 0 (down, either base). Otherwise `carry_out_n` is high, and it follows these inputs combinationally.
- R9: Two stages on one clock, with the low stage's `carry_out_n` driving the high stage's `carry_in_n`, count as a two-digit counter in all four base/direction combinations. This holds across presets applied in the middle of a count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset_en | input | 1 | High: load and show the jam inputs |
| jam | input | 4 | Parallel preset value |
| carry_in_n | input | 1 | Active-low count enable |
| bin_sel | input | 1 | 1 = binary base, 0 = decade base |
| up_sel | input | 1 | 1 = count up, 0 = count down |
| count | output | 4 | Current count |
| carry_out_n | output | 1 | Active-low terminal-count flag |

## Verification
A wrong stored count appears on `count` in the same cycle it is wrong. If it lands on or leaves a terminal value, it also appears on `carry_out_n` combinationally. A wrong wrap value or step direction shows at the port on the edge right after the terminal count. In a cascade, it also moves the upper digit one edge early or late. A preset that is not captured correctly shows on the first cycle after `preset_en` falls, so the bench compares both stages against a reference model after every edge.

// File: rtl/jud_pkg.sv
package jud_pkg;
  typedef enum logic {BASE_DEC = 1'b0, BASE_BIN = 1'b1} base_e;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/jud_rst_sync.sv
module jud_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = pipe_q[STAGES-1];
endmodule

// File: rtl/jud_next.sv
module jud_next
  import jud_pkg::*;
#(
  parameter int W       = 4,
  parameter int DEC_MAX = 9
) (
  input  logic [W-1:0] cnt,
  input  base_e        base,
  input  dir_e         dir,
  output logic [W-1:0] cnt_d
);
  localparam logic [W-1:0] BinTop = {W{1'b1}};
  localparam logic [W-1:0] DecTop = W'(DEC_MAX);

  logic [W-1:0] top;
  logic [W-1:0] inc;
  logic [W-1:0] dec;

  always_comb begin
    top = (base == BASE_BIN) ? BinTop : DecTop;
    inc = cnt + W'(1);
    dec = cnt - W'(1);
    if (dir == DIR_UP) cnt_d = (cnt >= top) ? '0 : inc;
    else               cnt_d = (cnt == '0) ? top : dec;
  end
endmodule

// File: rtl/jud_term.sv
module jud_term
  import jud_pkg::*;
#(
  parameter int W       = 4,
  parameter int DEC_MAX = 9
) (
  input  logic [W-1:0] cnt,
  input  base_e        base,
  input  dir_e         dir,
  input  logic         carry_in_n,
  output logic         carry_out_n
);
  localparam logic [W-1:0] BinTop = {W{1'b1}};
  localparam logic [W-1:0] DecTop = W'(DEC_MAX);

  logic at_end;

  always_comb begin
    if (dir == DIR_UP) at_end = (cnt == ((base == BASE_BIN) ? BinTop : DecTop));
    else               at_end = (cnt == '0);
    carry_out_n = ~(at_end & ~carry_in_n);
  end
endmodule

// File: rtl/jam_updown_counter.sv
module jam_updown_counter
  import jud_pkg::*;
#(
  parameter int W       = 4,
  parameter int DEC_MAX = 9,
  parameter int SYNC    = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         preset_en,
  input  logic [W-1:0] jam,
  input  logic         carry_in_n,
  input  logic         bin_sel,
  input  logic         up_sel,
  output logic [W-1:0] count,
  output logic         carry_out_n
);
  localparam logic [W-1:0] BinTop = {W{1'b1}};
  localparam logic [W-1:0] DecTop = W'(DEC_MAX);

  logic         rst_q_n;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         adv_en;
  base_e        base;
  dir_e         dir;

  assign base   = base_e'(bin_sel);
  assign dir    = dir_e'(up_sel);
  assign adv_en = ~carry_in_n & ~preset_en;

  jud_rst_sync #(.STAGES(SYNC)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  jud_next #(.W(W), .DEC_MAX(DEC_MAX)) u_next (
    .cnt(cnt_q), .base(base), .dir(dir), .cnt_d(cnt_d)
  );

  always_ff @(posedge clk or negedge rst_q_n or posedge preset_en) begin
    if (!rst_q_n)       cnt_q <= '0;
    else if (preset_en) cnt_q <= jam;
    else if (adv_en)    cnt_q <= cnt_d;
  end

  assign count = preset_en ? jam : cnt_q;

  jud_term #(.W(W), .DEC_MAX(DEC_MAX)) u_term (
    .cnt(count), .base(base), .dir(dir),
    .carry_in_n(carry_in_n), .carry_out_n(carry_out_n)
  );

  // R2: value captured while preset was high survives its release
  assert_preset_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || !rst_q_n)
    $fell(preset_en) |-> count == $past(jam));

  // R3: no advance while disabled
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || !rst_q_n || preset_en)
    (carry_in_n && !preset_en) |=> $stable(count));

  // R4: binary up wrap
  assert_bin_up_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n || !rst_q_n || preset_en)
    (adv_en && bin_sel && up_sel && count == BinTop) |=> count == '0);

  // R5: binary down wrap
  assert_bin_dn_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n || !rst_q_n || preset_en)
    (adv_en && bin_sel && !up_sel && count == '0) |=> count == BinTop);

  // R6: decade up from top or beyond goes to zero
  assert_dec_up_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n || !rst_q_n || preset_en)
    (adv_en && !bin_sel && up_sel && count >= DecTop) |=> count == '0);

  // R7: decade down wrap
  assert_dec_dn_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n || !rst_q_n || preset_en)
    (adv_en && !bin_sel && !up_sel && count == '0) |=> count == DecTop);

  // R8: carry-out only with carry-in asserted
  assert_carry_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_out_n |-> !carry_in_n);
endmodule

// File: tb/jam_updown_counter_bench.sv
`timescale 1ns/1ps
module jam_updown_counter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       preset_en;
  logic [3:0] jam_lo, jam_hi;
  logic       ci_lo;
  logic       bin_sel, up_sel;
  logic [3:0] cnt_lo, cnt_hi;
  logic       co_lo, co_hi;

  int n_vec  = 0;
  int n_fail = 0;
  int m_lo, m_hi;
  bit done = 0;

  always #5 clk = ~clk;

  jam_updown_counter u_jam_updown_counter (
    .clk(clk), .rst_n(rst_n), .preset_en(preset_en), .jam(jam_lo),
    .carry_in_n(ci_lo), .bin_sel(bin_sel), .up_sel(up_sel),
    .count(cnt_lo), .carry_out_n(co_lo)
  );

  jam_updown_counter u_jam_updown_counter_hi (
    .clk(clk), .rst_n(rst_n), .preset_en(preset_en), .jam(jam_hi),
    .carry_in_n(co_lo), .bin_sel(bin_sel), .up_sel(up_sel),
    .count(cnt_hi), .carry_out_n(co_hi)
  );

  function automatic int step_of(int v, bit up, bit bin);
    int mx = bin ? 15 : 9;
    if (up) return (v >= mx) ? 0 : v + 1;
    return (v == 0) ? mx : v - 1;
  endfunction

  function automatic bit co_of(int v, bit up, bit bin, bit ci);
    int mx = bin ? 15 : 9;
    bit hit = up ? (v == mx) : (v == 0);
    return !(hit && !ci);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare both stages against the model; req names the mode under test
  task automatic compare(string req);
    int v_lo = preset_en ? int'(jam_lo) : m_lo;
    int v_hi = preset_en ? int'(jam_hi) : m_hi;
    bit c_lo = co_of(v_lo, up_sel, bin_sel, ci_lo);
    chk({req, " R9 lo"}, int'(cnt_lo), v_lo);
    chk({req, " R9 hi"}, int'(cnt_hi), v_hi);
    chk("R8 co_lo", int'(co_lo), int'(c_lo));
    chk("R8 co_hi", int'(co_hi), int'(co_of(v_hi, up_sel, bin_sel, c_lo)));
  endtask

  // one clock: model update at the edge, check at the next falling edge
  task automatic tick(string req);
    @(posedge clk);
    begin
      bit clo = co_of(m_lo, up_sel, bin_sel, ci_lo);
      if (preset_en) begin
        m_lo = int'(jam_lo); m_hi = int'(jam_hi);
      end else begin
        if (!ci_lo) m_lo = step_of(m_lo, up_sel, bin_sel);
        if (!clo)   m_hi = step_of(m_hi, up_sel, bin_sel);
      end
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; preset_en = 1'b0; jam_lo = 4'd7; jam_hi = 4'd3;
    ci_lo = 1'b1; bin_sel = 1'b1; up_sel = 1'b1;
    m_lo = 0; m_hi = 0;
    #1;
    chk("R1 reset lo", int'(cnt_lo), 0);
    chk("R1 reset hi", int'(cnt_hi), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick("R3");
    // R3: enabled-off hold with carry-in high
    repeat (4) tick("R3");

    for (int mode = 0; mode < 4; mode++) begin
      string tag;
      bin_sel = mode[1];
      up_sel  = mode[0];
      case (mode)
        0: tag = "R7";
        1: tag = "R6";
        2: tag = "R5";
        default: tag = "R4";
      endcase
      // preset a starting point, including out-of-range decade values
      preset_en = 1'b1;
      jam_lo = (mode < 2) ? 4'd12 : 4'd14;
      jam_hi = 4'd0;
      #1;
      chk("R2 async lo", int'(cnt_lo), int'(jam_lo));
      chk("R2 async hi", int'(cnt_hi), int'(jam_hi));
      tick("R2");
      preset_en = 1'b0;
      ci_lo = 1'b0;
      for (int k = 0; k < 400; k++) begin
        tick(tag);
        ci_lo = ($urandom_range(0, 7) == 0);
        if ($urandom_range(0, 49) == 0) begin
          preset_en = 1'b1;
          jam_lo = 4'($urandom_range(0, 15));
          jam_hi = 4'($urandom_range(0, 15));
          #1;
          chk("R2 mid lo", int'(cnt_lo), int'(jam_lo));
          chk("R2 mid hi", int'(cnt_hi), int'(jam_hi));
          tick("R2");
          preset_en = 1'b0;
        end
      end
    end

    // R2: all-zero jam gives zero
    preset_en = 1'b1; jam_lo = 4'd0; jam_hi = 4'd0;
    #1;
    chk("R2 zero", int'(cnt_lo), 0);
    tick("R2");
    preset_en = 1'b0;
    tick("R3");

    // R1: asynchronous reset mid-cycle
    ci_lo = 1'b0; up_sel = 1'b1; bin_sel = 1'b1;
    tick("R4"); tick("R4");
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async lo", int'(cnt_lo), 0);
    chk("R1 async hi", int'(cnt_hi), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule